// File: doc/BRIEF.md
# Delayed Branch Sequencer

This block steers instruction fetch for a small 32-bit load-store core with 16-bit instructions. Each cycle in which the fetch side presents an instruction and does not stall, the block takes the decoded branch request for that instruction, a target address and any compare operation, and works out the address to fetch next. It also raises a squash strobe when the instruction already fetched behind the branch must be dropped.

The block holds the single condition flag T. Only the two compare operations write it: equality and signed greater-or-equal. Any other operation leaves T unchanged. A jump always takes effect one instruction late, so the instruction after it (the slot) still executes. Conditional branches on T come in two forms. The delayed form keeps its slot instruction. The immediate form squashes the following instruction when the branch is taken.

A branch that arrives while a slot is still pending is illegal. The block flags it on an error output and does not act on it.

Top module: `branch_seq`

## Requirements
- R1: After reset, `fetch_pc` equals the `RESET_PC` parameter, `t_flag` is 0, and `squash` and `br_err` are 0 while no instruction is presented.
- R2: An advancing cycle (`fetch_valid`=1, `stall`=0) that takes no branch sets `fetch_pc` to its old value plus 2, modulo 2^32. `br_kind` code 0 means no branch.
- R3: `br_kind` code 1 is the jump, which is always taken and always delayed. On an advancing cycle with no slot pending, `fetch_pc` becomes `br_target`, `squash` stays 0, and the next advancing instruction is the slot.
- R4: `br_kind` codes 2 (on T=1) and 3 (on T=0) are immediate conditional branches. When taken, `fetch_pc` becomes `br_target` and `squash` is 1 in that same cycle.
- R5: `br_kind` codes 4 (on T=1) and 5 (on T=0) are delayed conditional branches. When taken, `fetch_pc` becomes `br_target`, `squash` stays 0, and the next advancing instruction is the slot.
- R6: A conditional branch that is not taken behaves as R2 and leaves `squash` at 0. A delayed one (code 4 or 5) still makes the next advancing instruction a slot.
- R7: Codes 2 and 4 are taken exactly when T is 1. Codes 3 and 5 are taken exactly when T is 0. The value of T used is the one held before the cycle.
- R8: `cmp_op` code 1 (equality) on an advancing cycle sets T to 1 when `cmp_a` equals `cmp_b`, and to 0 otherwise.
- R9: `cmp_op` code 2 (greater-or-equal) on an advancing cycle sets T to 1 when `cmp_a` >= `cmp_b` as signed two's-complement 32-bit values, and to 0 otherwise.
- R10: `cmp_op` code 0 (any non-compare operation) never changes T.
- R11: A branch request (nonzero `br_kind`) on the advancing slot instruction raises `br_err` in that cycle. It is ignored: `fetch_pc` advances by 2, `squash` stays 0, and the instruction after it is not a slot.
- R12: In a cycle that does not advance (`stall`=1 or `fetch_valid`=0), `fetch_pc`, T and the slot state hold, and `squash` and `br_err` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | An instruction is presented this cycle |
| stall | input | 1 | Fetch side holds; nothing advances |
| br_kind | input | 3 | Branch request code of the presented instruction |
| br_target | input | 32 | Branch target address |
| cmp_op | input | 2 | Compare operation code of the presented instruction |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| fetch_pc | output | 32 | Next fetch address |
| squash | output | 1 | Drop the instruction fetched behind this one |
| t_flag | output | 1 | Current condition flag |
| br_err | output | 1 | Branch requested inside a delay slot |

## Verification
The bench sweeps every branch code against both T values, with and without a pending slot and with and without a preceding stall cycle. A design that tests T with the wrong polarity, squashes a delayed slot, or acts on a branch placed in a slot shows a wrong `fetch_pc` or a wrong strobe. Compares run over a grid of small signed operands and the sign-boundary extremes, which exposes an unsigned greater-or-equal. Cycles with non-compare operations carrying equal and unequal operands expose any write to T outside a compare. A stalled cycle placed just before a slot instruction shows whether the slot state is lost. A jump to the top of the address space checks that the increment wraps.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;

  typedef enum logic [2:0] {
    BK_NONE   = 3'd0,
    BK_JUMP_D = 3'd1,
    BK_IFT    = 3'd2,
    BK_IFF    = 3'd3,
    BK_IFT_D  = 3'd4,
    BK_IFF_D  = 3'd5
  } br_kind_e;

  typedef enum logic [1:0] {
    CMP_NONE = 2'd0,
    CMP_EQ   = 2'd1,
    CMP_GE   = 2'd2
  } cmp_op_e;

  function automatic logic kind_is_branch(br_kind_e k);
    return (k == BK_JUMP_D) || (k == BK_IFT) || (k == BK_IFF) ||
           (k == BK_IFT_D)  || (k == BK_IFF_D);
  endfunction

  function automatic logic kind_is_delayed(br_kind_e k);
    return (k == BK_JUMP_D) || (k == BK_IFT_D) || (k == BK_IFF_D);
  endfunction

  function automatic logic kind_cond_met(br_kind_e k, logic t);
    case (k)
      BK_JUMP_D:          return 1'b1;
      BK_IFT, BK_IFT_D:   return t;
      BK_IFF, BK_IFF_D:   return ~t;
      default:            return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tflag_unit.sv
module tflag_unit
  import branch_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              t_q
);

  function automatic logic signed_ge(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y);
    return $signed(x) >= $signed(y);
  endfunction

  cmp_op_e op_e;
  logic    cmp_write;
  logic    cmp_result;

  assign op_e      = cmp_op_e'(op);
  assign cmp_write = upd_en && ((op_e == CMP_EQ) || (op_e == CMP_GE));

  always_comb begin
    case (op_e)
      CMP_EQ:  cmp_result = (a == b);
      CMP_GE:  cmp_result = signed_ge(a, b);
      default: cmp_result = t_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         t_q <= 1'b0;
    else if (cmp_write) t_q <= cmp_result;
  end

  // R10 / R12: T moves only on an advancing compare
  a_r10_t_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en || (op == 2'd0)) |=> $stable(t_q));

  // R8: equal operands under equality compare leave T set
  a_r8_eq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (op == 2'd1) && (a == b)) |=> t_q);

  // R9: the most negative value is never >= zero
  a_r9_ge_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (op == 2'd2) && a[DATA_W-1] && (b == '0)) |=> !t_q);

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import branch_seq_pkg::*;
(
  input  logic       advance,
  input  logic [2:0] kind,
  input  logic       t_cur,
  input  logic       slot_pend,
  output logic       take,
  output logic       squash,
  output logic       err,
  output logic       arm_slot
);

  br_kind_e k;
  logic     is_br;
  logic     legal_br;

  assign k        = br_kind_e'(kind);
  assign is_br    = kind_is_branch(k);
  assign legal_br = advance && is_br && !slot_pend;

  assign err      = advance && is_br && slot_pend;
  assign take     = legal_br && kind_cond_met(k, t_cur);
  assign arm_slot = legal_br && kind_is_delayed(k);
  assign squash   = take && !kind_is_delayed(k);

  always_comb begin
    // R11: an illegal branch neither redirects nor squashes
    a_r11_err_inert: assert (!(err && (take || squash || arm_slot)));
    // R3 / R5: a delayed branch never squashes its slot
    a_r5_no_slot_squash: assert (!(squash && arm_slot));
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              take,
  input  logic              arm_slot,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc_q,
  output logic              slot_q
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  function automatic logic [ADDR_W-1:0] pc_step(logic [ADDR_W-1:0] p);
    return p + STEP;
  endfunction

  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    if (!advance)  pc_d = pc_q;
    else if (take) pc_d = target;
    else           pc_d = pc_step(pc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      slot_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (advance) slot_q <= arm_slot;
    end
  end

  // R12: nothing moves on a non-advancing cycle
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(pc_q) && $stable(slot_q)));

  // R3 / R4 / R5: a taken branch lands on its target
  a_r3_lands_target: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && take) |=> (pc_q == $past(target)));

  // R2: straight-line flow steps by one 16-bit instruction
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !take) |=> (pc_q == $past(pc_q) + STEP));

  // R11: a slot lasts for exactly one advancing instruction
  a_r11_slot_once: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && slot_q) |=> !slot_q);

endmodule

// File: rtl/branch_seq.sv
module branch_seq #(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic              stall,
  input  logic [2:0]        br_kind,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [1:0]        cmp_op,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              squash,
  output logic              t_flag,
  output logic              br_err
);

  logic advance;
  logic take;
  logic arm_slot;
  logic slot_pend;
  logic t_q;

  assign advance = fetch_valid && !stall;

  tflag_unit #(.DATA_W(DATA_W)) u_tflag (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (advance),
    .op     (cmp_op),
    .a      (cmp_a),
    .b      (cmp_b),
    .t_q    (t_q)
  );

  branch_resolve u_resolve (
    .advance   (advance),
    .kind      (br_kind),
    .t_cur     (t_q),
    .slot_pend (slot_pend),
    .take      (take),
    .squash    (squash),
    .err       (br_err),
    .arm_slot  (arm_slot)
  );

  pc_sequencer #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .take     (take),
    .arm_slot (arm_slot),
    .target   (br_target),
    .pc_q     (fetch_pc),
    .slot_q   (slot_pend)
  );

  assign t_flag = t_q;

  // R12: strobes are silent when nothing advances
  a_r12_quiet_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |-> (!squash && !br_err));

  // R4: squash only comes from an immediate conditional code
  a_r4_squash_kind: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> ((br_kind == 3'd2) || (br_kind == 3'd3)));

endmodule

// File: tb/branch_seq_tb_top.sv
`timescale 1ns/100ps
module branch_seq_tb_top;

  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        stall = 1'b0;
  logic [2:0]  br_kind = 3'd0;
  logic [31:0] br_target = '0;
  logic [1:0]  cmp_op = 2'd0;
  logic [31:0] cmp_a = '0;
  logic [31:0] cmp_b = '0;
  logic [31:0] fetch_pc;
  logic        squash;
  logic        t_flag;
  logic        br_err;

  int tests = 0;
  int fails = 0;

  // bench-side state
  logic [31:0] m_pc;
  logic        m_t;
  logic        m_slot;

  always #2.5 clk = ~clk;

  branch_seq #(.ADDR_W(32), .DATA_W(32), .RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .stall(stall),
    .br_kind(br_kind), .br_target(br_target), .cmp_op(cmp_op),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .fetch_pc(fetch_pc), .squash(squash),
    .t_flag(t_flag), .br_err(br_err)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One instruction slot: drive, check strobes, clock, check state.
  task automatic apply(logic v, logic s, logic [2:0] k, logic [31:0] tgt,
                       logic [1:0] cop, logic [31:0] a, logic [31:0] b);
    logic adv, isbr, cond, dly, err, taken, sq, nt;
    logic [31:0] npc;
    string tag, ttag;
    fetch_valid = v; stall = s; br_kind = k; br_target = tgt;
    cmp_op = cop; cmp_a = a; cmp_b = b;
    adv  = v && !s;
    isbr = (k >= 3'd1) && (k <= 3'd5);
    dly  = (k == 3'd1) || (k == 3'd4) || (k == 3'd5);
    // R7: codes 2 and 4 follow T, codes 3 and 5 follow its inverse
    cond = (k == 3'd1) ? 1'b1 : ((k == 3'd2) || (k == 3'd4)) ? m_t : !m_t;
    err   = adv && isbr && m_slot;
    taken = adv && isbr && !m_slot && cond;
    sq    = taken && !dly;
    npc   = !adv ? m_pc : (taken ? tgt : m_pc + 32'd2);
    if (!adv)                 nt = m_t;
    else if (cop == 2'd1)     nt = (a == b);
    else if (cop == 2'd2)     nt = ((a ^ 32'h8000_0000) >= (b ^ 32'h8000_0000));
    else                      nt = m_t;
    if (!adv)                       tag = "R12";
    else if (err)                   tag = "R11";
    else if (k == 3'd0)             tag = "R2";
    else if (k == 3'd1)             tag = "R3";
    else if (!taken)                tag = "R6";
    else if (k == 3'd2 || k == 3'd3) tag = "R4";
    else                            tag = "R5";
    if (!adv)              ttag = "R12";
    else if (cop == 2'd1)  ttag = "R8";
    else if (cop == 2'd2)  ttag = "R9";
    else                   ttag = "R10";
    #1;
    chk(tag, "squash", {31'd0, squash}, {31'd0, sq});
    chk(tag, "br_err", {31'd0, br_err}, {31'd0, err});
    @(posedge clk);
    @(negedge clk);
    if (adv) m_slot = isbr && !m_slot && dly;
    m_pc = npc;
    m_t  = nt;
    chk(tag, "fetch_pc", fetch_pc, m_pc);
    chk(ttag, "t_flag", {31'd0, t_flag}, {31'd0, m_t});
    fetch_valid = 1'b0; stall = 1'b0; br_kind = 3'd0; cmp_op = 2'd0;
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    m_pc = RST_PC; m_t = 1'b0; m_slot = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "fetch_pc", fetch_pc, RST_PC);
    chk("R1", "t_flag", {31'd0, t_flag}, 32'd0);
    chk("R1", "squash", {31'd0, squash}, 32'd0);
    chk("R1", "br_err", {31'd0, br_err}, 32'd0);
    @(negedge clk);

    // Branch sweep: every code x T value x slot pending x stall before
    for (int pre = 0; pre < 2; pre++)
      for (int k = 0; k < 6; k++)
        for (int tv = 0; tv < 2; tv++)
          for (int st = 0; st < 2; st++) begin
            apply(1, 0, 3'd0, '0, 2'd1, 32'd5, tv ? 32'd5 : 32'd6);
            if (pre == 1) apply(1, 0, 3'd1, 32'h0000_4000 + 32'(k * 64), 2'd0, '0, '0);
            if (st == 1) begin
              apply(1, 1, 3'(k), 32'h0000_8000, 2'd1, 32'd1, 32'd1);
              apply(0, 0, 3'(k), 32'h0000_8800, 2'd2, 32'd1, 32'd2);
            end
            apply(1, 0, 3'(k), 32'h0000_2000 + 32'(k * 16 + tv * 4), 2'd0, '0, '0);
            apply(1, 0, 3'd0, '0, 2'd0, 32'd3, 32'd3);
          end

    // Compare grid over small signed operands
    for (int op = 1; op < 3; op++)
      for (int a = -4; a < 4; a++)
        for (int b = -4; b < 4; b++)
          apply(1, 0, 3'd0, '0, 2'(op), 32'(a), 32'(b));

    // R9 sign-boundary extremes
    apply(1, 0, 3'd0, '0, 2'd2, 32'h8000_0000, 32'h7FFF_FFFF);
    apply(1, 0, 3'd0, '0, 2'd2, 32'h7FFF_FFFF, 32'h8000_0000);
    apply(1, 0, 3'd0, '0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0000);
    apply(1, 0, 3'd0, '0, 2'd2, 32'h8000_0000, 32'h8000_0000);

    // R10: non-compare operations with equal and unequal operands
    apply(1, 0, 3'd0, '0, 2'd1, 32'd9, 32'd9);
    apply(1, 0, 3'd0, '0, 2'd0, 32'd1, 32'd2);
    apply(1, 0, 3'd0, '0, 2'd2, 32'd0, 32'd1);
    apply(1, 0, 3'd0, '0, 2'd0, 32'd7, 32'd7);

    // R2 wrap of the increment
    apply(1, 0, 3'd1, 32'hFFFF_FFFE, 2'd0, '0, '0);
    apply(1, 0, 3'd0, '0, 2'd0, '0, '0);
    chk("R2", "wrap", fetch_pc, 32'h0000_0000);

    // R11: branch back-to-back inside a delayed conditional slot
    apply(1, 0, 3'd0, '0, 2'd1, 32'd2, 32'd2);
    apply(1, 0, 3'd4, 32'h0000_3000, 2'd0, '0, '0);
    apply(1, 0, 3'd2, 32'h0000_3100, 2'd0, '0, '0);
    apply(1, 0, 3'd2, 32'h0000_3200, 2'd0, '0, '0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule